// File: doc/BRIEF.md
# Cascadable Bidirectional Line Data Sampler

This block is the capture front end of a panel column driver. It gathers one display line of 6-bit pixel codes into a parallel line buffer, one group of six channels per rising clock edge. A start token arriving on one of two cascade pins arms the capture. A direction input chooses which pin receives the token and which one passes it on. It also chooses whether groups fill from the lowest channels upward or from the highest channels downward. Either half of the input bus can be bitwise complemented on the fly. This lets the source that sends the data cut the number of bus toggles.

After the last group of the line is written, the block drives a one-clock pulse on the opposite cascade pin, so several devices can be chained and fill a wider panel one after another. The buffer contents and a one-hot write strobe per group are presented on registered outputs for the next stage, the output latch. Each cascade pin is modelled as a separate input, output and output-enable.

Top module: `line_sampler_top`

## Requirements
- R1: After synchronous reset the line buffer reads all zero, no group strobe is high, both cascade outputs are low and no capture is in progress.
- R2: Each captured group holds six codes. Code j is taken from `din[6j+5:6j]`, with bit 5 as the MSB. It lands on channel 6g+j of group g, which is `line_q[(6g+j)*6 +: 6]`, so codes map to ascending channels in both directions.
- R3: When `inv_lo` is high at a capture edge, codes 0 to 2 are stored bitwise complemented (07h is stored as 38h). When `inv_hi` is high, codes 3 to 5 are stored complemented (15h is stored as 2Ah). The two halves are independent.
- R4: With `dir_up` high, the token is taken from `cas_a_i`, and successive captures fill groups 0, 1, 2 and so on up to NUM_GRP-1.
- R5: With `dir_up` low, the token is taken from `cas_b_i`, and captures fill group NUM_GRP-1 first and group 0 last.
- R6: A start is recognised at a rising edge where the selected cascade input is high and was low at the previous edge. Nothing is written at that edge. The first group is written at the next edge. The strobe `grp_we[g]` is high for exactly the one cycle after the edge that wrote group g, and the new data is already visible in that cycle.
- R7: The edge that writes the final group also raises the opposite cascade output (`cas_b_o` when shifting up, `cas_a_o` when shifting down) for exactly one cycle.
- R8: A start input held high for several clocks counts as one start, and capture goes on normally while it stays high.
- R9: Once the line is complete, further clocks write nothing and leave the buffer unchanged until a new start arrives.
- R10: A new start during a line restarts the capture from the first group of the direction in force.
- R11: `cas_b_oe` equals `dir_up` and `cas_a_oe` equals its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | 1: token enters on A and groups fill upward; 0: token enters on B and groups fill downward |
| cas_a_i | input | 1 | Cascade pin A, input side |
| cas_b_i | input | 1 | Cascade pin B, input side |
| cas_a_o | output | 1 | Cascade pin A, output side (end-of-line pulse when shifting down) |
| cas_b_o | output | 1 | Cascade pin B, output side (end-of-line pulse when shifting up) |
| cas_a_oe | output | 1 | Output enable for pin A |
| cas_b_oe | output | 1 | Output enable for pin B |
| inv_lo | input | 1 | Complement codes 0 to 2 |
| inv_hi | input | 1 | Complement codes 3 to 5 |
| din | input | 36 | Six 6-bit codes, code j at bits 6j+5:6j |
| line_q | output | 2412 | Line buffer, channel c at bits 6c+5:6c |
| grp_we | output | 67 | One-hot strobe, one bit per written group |

## Verification
The hardest case to reach is a restart that lands in the middle of a line. The bench has to lower the held token, let some groups be written, and then raise the same pin again so that a clean low-to-high edge occurs partway through. It then checks that no write happens at the restart edge and that filling starts again at the first group. A held token that overlaps the first data groups is also driven on purpose, to show that a level still high at later edges is never taken as a new start. The downward line is sent with the two inversion controls switched group by group, using the codes 07h and 15h, so the complement of each half is checked in both directions.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic {
    SHIFT_DOWN = 1'b0,
    SHIFT_UP   = 1'b1
  } shift_dir_t;

  function automatic logic [5:0] flip_code(input logic [5:0] c, input logic en);
    return en ? ~c : c;
  endfunction
endpackage

// File: rtl/lsd_start_detect.sv
module lsd_start_detect (
  input  logic clk,
  input  logic rst,
  input  logic dir_up,
  input  logic pin_a,
  input  logic pin_b,
  output logic start
);
  logic sel_now;
  logic sel_prev;

  assign sel_now = dir_up ? pin_a : pin_b;

  always_ff @(posedge clk) begin
    if (rst) sel_prev <= 1'b0;
    else     sel_prev <= sel_now;
  end

  assign start = sel_now & ~sel_prev;

  // R8: a level that stays high cannot start twice in a row
  a_r8_single_start: assert property (@(posedge clk) disable iff (rst)
    (start && $stable(dir_up)) |=> (!start || !$stable(dir_up)));
endmodule

// File: rtl/lsd_sequencer.sv
module lsd_sequencer #(
  parameter int NUM_GRP = 67,
  localparam int CW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dir_up,
  output logic          wr_en,
  output logic [CW-1:0] wr_grp,
  output logic          done_up,
  output logic          done_dn
);
  import lsd_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(NUM_GRP - 1);

  logic          active;
  logic [CW-1:0] cnt;
  shift_dir_t    dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      dir_q   <= SHIFT_UP;
      done_up <= 1'b0;
      done_dn <= 1'b0;
    end else begin
      done_up <= 1'b0;
      done_dn <= 1'b0;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        dir_q  <= dir_up ? SHIFT_UP : SHIFT_DOWN;
      end else if (active) begin
        if (cnt == LAST) begin
          active  <= 1'b0;
          done_up <= (dir_q == SHIFT_UP);
          done_dn <= (dir_q == SHIFT_DOWN);
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign wr_en  = active & ~start;
  assign wr_grp = (dir_q == SHIFT_UP) ? cnt : (LAST - cnt);

  // R10: a start always rearms from the first group
  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    start |=> (active && cnt == '0));
  // R7: end-of-line pulse lasts a single cycle and never on both pins
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (done_up || done_dn) |=> !(done_up || done_dn));
  a_r7_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(done_up && done_dn));
  // R9: idle stays idle without a start
  a_r9_stay_idle: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> !active);
endmodule

// File: rtl/lsd_code_invert.sv
module lsd_code_invert #(
  parameter int CODES  = 6,
  parameter int CODE_W = 6,
  localparam int BUS_W = CODES * CODE_W
) (
  input  logic [BUS_W-1:0] raw,
  input  logic             inv_lo,
  input  logic             inv_hi,
  output logic [BUS_W-1:0] cooked
);
  for (genvar j = 0; j < CODES; j++) begin : g_code
    if (j < CODES / 2) begin : g_lo
      assign cooked[j*CODE_W +: CODE_W] = raw[j*CODE_W +: CODE_W] ^ {CODE_W{inv_lo}};
    end else begin : g_hi
      assign cooked[j*CODE_W +: CODE_W] = raw[j*CODE_W +: CODE_W] ^ {CODE_W{inv_hi}};
    end
  end
endmodule

// File: rtl/lsd_line_store.sv
module lsd_line_store #(
  parameter int NUM_GRP = 67,
  parameter int GRP_W   = 36,
  localparam int CW     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int LINE_W = NUM_GRP * GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_grp,
  input  logic [GRP_W-1:0]  wr_data,
  output logic [LINE_W-1:0] line_q,
  output logic [NUM_GRP-1:0] grp_we
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit = wr_en && (wr_grp == CW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        line_q[g*GRP_W +: GRP_W] <= '0;
        grp_we[g]                <= 1'b0;
      end else begin
        grp_we[g] <= hit;
        if (hit) line_q[g*GRP_W +: GRP_W] <= wr_data;
      end
    end
  end

  // R6: at most one group strobe per cycle
  a_r6_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grp_we));
  // R9: buffer holds when nothing is written
  a_r9_hold_line: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(line_q));
  // R6: a write request shows up as a strobe one cycle later
  a_r6_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (grp_we != '0));
endmodule

// File: rtl/line_sampler_top.sv
module line_sampler_top #(
  parameter int NUM_GRP = 67,
  parameter int CODES   = 6,
  parameter int CODE_W  = 6,
  localparam int BUS_W  = CODES * CODE_W,
  localparam int LINE_W = NUM_GRP * BUS_W,
  localparam int CW     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dir_up,
  input  logic               cas_a_i,
  input  logic               cas_b_i,
  output logic               cas_a_o,
  output logic               cas_b_o,
  output logic               cas_a_oe,
  output logic               cas_b_oe,
  input  logic               inv_lo,
  input  logic               inv_hi,
  input  logic [BUS_W-1:0]   din,
  output logic [LINE_W-1:0]  line_q,
  output logic [NUM_GRP-1:0] grp_we
);
  logic          start;
  logic          wr_en;
  logic [CW-1:0] wr_grp;
  logic [BUS_W-1:0] cooked;

  lsd_start_detect u_start (
    .clk(clk), .rst(rst), .dir_up(dir_up),
    .pin_a(cas_a_i), .pin_b(cas_b_i), .start(start)
  );

  lsd_sequencer #(.NUM_GRP(NUM_GRP)) u_seq (
    .clk(clk), .rst(rst), .start(start), .dir_up(dir_up),
    .wr_en(wr_en), .wr_grp(wr_grp), .done_up(cas_b_o), .done_dn(cas_a_o)
  );

  lsd_code_invert #(.CODES(CODES), .CODE_W(CODE_W)) u_inv (
    .raw(din), .inv_lo(inv_lo), .inv_hi(inv_hi), .cooked(cooked)
  );

  lsd_line_store #(.NUM_GRP(NUM_GRP), .GRP_W(BUS_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_grp(wr_grp),
    .wr_data(cooked), .line_q(line_q), .grp_we(grp_we)
  );

  assign cas_b_oe = dir_up;
  assign cas_a_oe = ~dir_up;

  // R11: exactly one pin drives at any time
  a_r11_oe_excl: assert property (@(posedge clk) disable iff (rst)
    (cas_a_oe ^ cas_b_oe));
  // R7: the end pulse coincides with a group strobe
  a_r7_done_with_write: assert property (@(posedge clk) disable iff (rst)
    (cas_a_o || cas_b_o) |-> (grp_we != '0));
endmodule

// File: tb/tb_line_sampler_top.sv
module tb_line_sampler_top;
  localparam int NUM_GRP = 67;
  localparam int BUS_W   = 36;
  localparam int LINE_W  = NUM_GRP * BUS_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_up = 1'b1, cas_a_i = 1'b0, cas_b_i = 1'b0, inv_lo = 1'b0, inv_hi = 1'b0;
  logic [BUS_W-1:0] din = '0;
  logic cas_a_o, cas_b_o, cas_a_oe, cas_b_oe;
  logic [LINE_W-1:0] line_q;
  logic [NUM_GRP-1:0] grp_we;

  line_sampler_top dut (
    .clk(clk), .rst(rst), .dir_up(dir_up), .cas_a_i(cas_a_i), .cas_b_i(cas_b_i),
    .cas_a_o(cas_a_o), .cas_b_o(cas_b_o), .cas_a_oe(cas_a_oe), .cas_b_oe(cas_b_oe),
    .inv_lo(inv_lo), .inv_hi(inv_hi), .din(din), .line_q(line_q), .grp_we(grp_we)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int hold_left = 0;
  bit finished = 1'b0;
  int q_idx[$];
  logic [BUS_W-1:0] q_dat[$];
  logic [LINE_W-1:0] mirror = '0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(posedge clk) begin
    #1;
    if (!rst && grp_we != '0) begin
      if (q_idx.size() == 0) begin
        chk(1'b0, "R9 unexpected strobe", 128'(grp_we), 0);
      end else begin
        int idx;
        logic [BUS_W-1:0] d;
        logic [NUM_GRP-1:0] oh;
        idx = q_idx.pop_front();
        d   = q_dat.pop_front();
        oh  = '0;
        oh[idx] = 1'b1;
        chk(grp_we == oh, "R6 R4 R5 strobe order", 128'(grp_we), 128'(oh));
        chk(line_q[idx*BUS_W +: BUS_W] == d, "R2 R3 group data",
            128'(line_q[idx*BUS_W +: BUS_W]), 128'(d));
      end
    end
  end

  task automatic set_pin(input bit fwd, input logic v);
    if (fwd) cas_a_i = v; else cas_b_i = v;
  endtask

  task automatic send_start(input bit fwd, input int hold);
    @(negedge clk);
    dir_up = fwd;
    set_pin(fwd, 1'b1);
    din = 36'hFFF_FFFF_FF;
    hold_left = hold - 1;
  endtask

  task automatic send_group(input int seq, input bit fwd, input bit il, input bit ih,
                            input logic [BUS_W-1:0] raw);
    int idx;
    logic [BUS_W-1:0] exp;
    @(negedge clk);
    if (hold_left > 0) hold_left--; else set_pin(fwd, 1'b0);
    din = raw; inv_lo = il; inv_hi = ih;
    exp = raw ^ {{18{ih}}, {18{il}}};
    idx = fwd ? seq : NUM_GRP - 1 - seq;
    q_idx.push_back(idx);
    q_dat.push_back(exp);
    mirror[idx*BUS_W +: BUS_W] = exp;
  endtask

  task automatic check_done(input bit fwd);
    @(posedge clk); #1;
    chk((fwd ? cas_b_o : cas_a_o) == 1'b1, "R7 end pulse high", 1'b1 & (fwd ? cas_b_o : cas_a_o), 1);
    chk((fwd ? cas_a_o : cas_b_o) == 1'b0, "R7 wrong pin quiet", 1'b1 & (fwd ? cas_a_o : cas_b_o), 0);
    @(posedge clk); #1;
    chk(cas_a_o == 1'b0 && cas_b_o == 1'b0, "R7 end pulse one cycle", {cas_a_o, cas_b_o}, 0);
  endtask

  task automatic check_image(input string req);
    chk(q_idx.size() == 0, req, q_idx.size(), 0);
    chk(line_q == mirror, req, 128'(line_q ^ mirror), 0);
  endtask

  task automatic full_line(input bit fwd, input int hold, input int pat);
    send_start(fwd, hold);
    for (int s = 0; s < NUM_GRP; s++) begin
      logic [BUS_W-1:0] raw;
      bit il, ih;
      raw = {6'(s + pat), 6'(s * 3), 6'h15, 6'(pat), 6'(s ^ 6'h2A), 6'h07};
      il = (pat != 0) && s[0];
      ih = (pat != 0) && s[1];
      send_group(s, fwd, il, ih, raw);
    end
    check_done(fwd);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(line_q == '0, "R1 buffer clear", 128'(line_q[127:0]), 0);
    chk(grp_we == '0, "R1 no strobe", 128'(grp_we), 0);
    chk(cas_a_o == 0 && cas_b_o == 0, "R1 cascade outputs low", {cas_a_o, cas_b_o}, 0);
    chk(cas_b_oe == 1 && cas_a_oe == 0, "R11 enables shifting up", {cas_a_oe, cas_b_oe}, 2'b01);
    @(negedge clk); rst = 1'b0;

    // R4 R8: upward line with a token held high for three clocks
    full_line(1'b1, 3, 0);
    check_image("R4 R2 upward image");

    // R9: idle clocks change nothing
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      din = {k[5:0], 30'h1234_5678};
      cas_a_i = 1'b0;
    end
    @(posedge clk); #1;
    check_image("R9 idle keeps buffer");

    // R5 R3: downward line with inversion toggling
    @(negedge clk); dir_up = 1'b0;
    @(posedge clk); #1;
    chk(cas_a_oe == 1 && cas_b_oe == 0, "R11 enables shifting down", {cas_a_oe, cas_b_oe}, 2'b10);
    full_line(1'b0, 1, 5);
    check_image("R5 R3 downward image");

    // R10: restart in the middle of an upward line
    send_start(1'b1, 1);
    for (int s = 0; s < 10; s++) send_group(s, 1'b1, 1'b0, 1'b1, {30'h0ABC_DEF0, 6'(s)});
    send_start(1'b1, 2);
    @(posedge clk); #1;
    chk(q_idx.size() == 0, "R10 restart edge writes nothing", q_idx.size(), 0);
    for (int s = 0; s < NUM_GRP; s++) send_group(s, 1'b1, s[2], 1'b0, {6'(s), 30'h1357_9BDF});
    check_done(1'b1);
    check_image("R10 restart image");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule